// File: doc/BRIEF.md
# Credit-Based Drop-Tail Link Buffer

This block models one directed link between two simulated network nodes. A credit counter on the sending side limits how many packets may be in flight. A bounded input queue on the receiving side holds arriving packets until the downstream consumer takes them. Both ends use a valid/ready handshake. Each packet that leaves the queue toward the consumer gives one credit back to the sender. The return goes through a single registered stage.

Hardware routing with cycles can deadlock when buffers only back-pressure. This link avoids that by discarding instead. When an arrival finds the queue one short of its depth, so that the arrival would fill it completely, the newest packet is thrown away and its credit is returned at once. The queue therefore never stays full, and the sender always regains credit. A saturating counter reports how many packets were discarded, for throughput statistics.

Top module: `credit_droptail_link`

## Requirements
- R1: After reset, `src_ready` is 1 (the sender holds DEPTH credits), `dst_valid` is 0 and `drop_count` is 0.
- R2: A packet is accepted only in a cycle where `src_valid` and `src_ready` are both 1. Each accepted packet consumes one credit. `src_ready` is 0 whenever the credit count is zero.
- R3: Packets that are kept are delivered on `dst_data` in the order they were accepted. A packet accepted at a clock edge is offered with `dst_valid` = 1 from the following cycle.
- R4: An accepted packet is discarded when DEPTH-1 packets are already stored at that edge, counted before any same-cycle delivery. Older packets stay in the queue, the discarded packet is never delivered, and `drop_count` rises by one at the same edge.
- R5: Every delivery (`dst_valid` and `dst_ready` both 1) returns one credit. The credit can be spent from the second cycle after the delivery.
- R6: When a delivery and a discard happen in the same cycle, two credits come back together in the same later cycle.
- R7: While `dst_valid` is 1 and `dst_ready` is 0, `dst_valid` stays 1 and `dst_data` stays unchanged.
- R8: `drop_count` saturates at 2^CNT_W-1 and holds that value on further discards.
- R9: Credits are neither created nor lost. The credit count never exceeds DEPTH. With the queue drained and returns settled, exactly DEPTH packets are accepted back to back while `dst_ready` is 0, and the following cycle has `src_ready` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| src_valid | input | 1 | Sender offers a packet |
| src_ready | output | 1 | Sender holds at least one credit |
| src_data | input | DATA_W | Packet offered by the sender |
| dst_valid | output | 1 | Queue holds a packet for the consumer |
| dst_ready | input | 1 | Consumer takes the head packet |
| dst_data | output | DATA_W | Head packet of the queue |
| drop_count | output | CNT_W | Saturating count of discarded packets |

## Verification
A leaked or duplicated credit shows up at `src_ready`. A lost credit first appears as a one-cycle gap where none should be, and within DEPTH further sends the sender stalls forever. A spare credit shows up as a missing low cycle during sustained discards, or as DEPTH+1 back-to-back accepts. A wrong occupancy or pointer shows up on the next delivery, as reordered, repeated or missing data against the scoreboard, or as a discard at the wrong count. The register in the credit return means an error in the return amount appears exactly two cycles after the delivery or discard that caused it.

// File: rtl/credit_link_pkg.sv
// Shared types for the credit-based drop-tail link.
// Assumes at most two credits are returned in one cycle (one delivery, one discard).
package credit_link_pkg;
    // Number of credits handed back to the sender in one cycle: 0, 1 or 2.
    typedef logic [1:0] credit_ret_t;
endpackage

// File: rtl/link_credit_counter.sv
// Sender side of the link: holds the credit count and grants sends.
// Assumes credit returns arrive from a registered path and never push the
// count above DEPTH (the receiver returns only credits that were spent).
module link_credit_counter
    import credit_link_pkg::*;
#(
    parameter int DEPTH = 4,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          src_valid,
    input  credit_ret_t   ret_i,
    output logic          src_ready,
    output logic          send_o,
    output logic [CW-1:0] credits_o
);
    logic [CW-1:0] credits_q;

    // Grant a send only while a credit is held.
    always_comb begin
        src_ready = (credits_q != '0);
        send_o    = src_valid && src_ready;
        credits_o = credits_q;
    end

    // Spend one credit per send, add the credits returned this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            credits_q <= CW'(DEPTH);
        end else begin
            credits_q <= credits_q - CW'(send_o) + CW'(ret_i);
        end
    end

    // Two credits returned together leave at least two credits on the next cycle.
    assert_double_credit_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i == 2'd2) |=> (int'(credits_q) >= 2));

    // The credit count stays within the buffer depth.
    assert_credit_cap_R9: assert property (@(posedge clk) disable iff (!rst_n)
        int'(credits_q) <= DEPTH);
endmodule

// File: rtl/link_droptail_fifo.sv
// Receiver side of the link: a bounded queue that discards the newest arrival
// whenever that arrival would fill every slot.
// Assumes DEPTH >= 2 and that the sender never has more than DEPTH packets
// outstanding (the credit scheme guarantees this).
module link_droptail_fifo #(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32,
    localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [DATA_W-1:0] push_data_i,
    input  logic              dst_ready,
    output logic              dst_valid,
    output logic [DATA_W-1:0] dst_data,
    output logic              pop_o,
    output logic              drop_o,
    output logic [CW-1:0]     occ_o
);
    logic [DATA_W-1:0] mem_q [DEPTH];
    logic [IW-1:0]     head_q, tail_q;
    logic [CW-1:0]     occ_q;
    logic              keep;

    // Advance a slot index with wrap at DEPTH.
    function automatic logic [IW-1:0] next_idx(input logic [IW-1:0] idx);
        return (idx == IW'(DEPTH - 1)) ? '0 : idx + 1'b1;
    endfunction

    // Decide delivery, discard and keep from the occupancy before this edge.
    always_comb begin
        dst_valid = (occ_q != '0);
        dst_data  = mem_q[head_q];
        pop_o     = dst_valid && dst_ready;
        drop_o    = push_i && (occ_q == CW'(DEPTH - 1));
        keep      = push_i && !drop_o;
        occ_o     = occ_q;
    end

    // Store a kept arrival at the tail slot.
    always_ff @(posedge clk) begin
        if (keep) begin
            mem_q[tail_q] <= push_data_i;
        end
    end

    // Move pointers and occupancy for kept arrivals and deliveries.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            occ_q  <= '0;
        end else begin
            if (keep)  tail_q <= next_idx(tail_q);
            if (pop_o) head_q <= next_idx(head_q);
            occ_q <= occ_q + CW'(keep) - CW'(pop_o);
        end
    end

    // A stalled head packet stays offered and unchanged.
    assert_hold_head_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (dst_valid && !dst_ready) |=> (dst_valid && $stable(dst_data)));

    // Discarding keeps the queue short of full after every edge.
    assert_below_full_R4: assert property (@(posedge clk) disable iff (!rst_n)
        int'(occ_q) <= DEPTH - 1);
endmodule

// File: rtl/link_credit_return.sv
// Registered credit return path: one credit per delivery plus one per discard,
// handed to the sender one cycle later.
// Assumes at most one delivery and one discard per cycle.
module link_credit_return
    import credit_link_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        pop_i,
    input  logic        drop_i,
    output credit_ret_t ret_o
);
    credit_ret_t ret_q;

    // Register the number of credits freed in this cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ret_q <= '0;
        end else begin
            ret_q <= credit_ret_t'(pop_i) + credit_ret_t'(drop_i);
        end
    end

    // Present the registered return to the sender.
    always_comb ret_o = ret_q;
endmodule

// File: rtl/link_drop_stats.sv
// Saturating count of discarded packets.
// Assumes at most one discard per cycle.
module link_drop_stats #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             drop_i,
    output logic [CNT_W-1:0] count_o
);
    logic [CNT_W-1:0] cnt_q;

    // Count discards and stop at the all-ones value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (drop_i && (cnt_q != '1)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    // Expose the count.
    always_comb count_o = cnt_q;

    // Once saturated, the count does not wrap.
    assert_saturate_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '1) |=> (cnt_q == '1));
endmodule

// File: rtl/credit_droptail_link.sv
// One directed simulated network link: credit-limited sender, drop-tail
// receive queue, registered credit return and discard statistics.
// Assumes the consumer follows valid/ready and DEPTH >= 2.
module credit_droptail_link
    import credit_link_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              src_valid,
    output logic              src_ready,
    input  logic [DATA_W-1:0] src_data,
    output logic              dst_valid,
    input  logic              dst_ready,
    output logic [DATA_W-1:0] dst_data,
    output logic [CNT_W-1:0]  drop_count
);
    localparam int CW = $clog2(DEPTH + 1);

    logic          send;
    logic          pop;
    logic          drop;
    credit_ret_t   ret;
    logic [CW-1:0] credits;
    logic [CW-1:0] occ;

    link_credit_counter #(.DEPTH(DEPTH)) u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .src_valid (src_valid),
        .ret_i     (ret),
        .src_ready (src_ready),
        .send_o    (send),
        .credits_o (credits)
    );

    link_droptail_fifo #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_rx (
        .clk         (clk),
        .rst_n       (rst_n),
        .push_i      (send),
        .push_data_i (src_data),
        .dst_ready   (dst_ready),
        .dst_valid   (dst_valid),
        .dst_data    (dst_data),
        .pop_o       (pop),
        .drop_o      (drop),
        .occ_o       (occ)
    );

    link_credit_return u_ret (
        .clk    (clk),
        .rst_n  (rst_n),
        .pop_i  (pop),
        .drop_i (drop),
        .ret_o  (ret)
    );

    link_drop_stats #(.CNT_W(CNT_W)) u_stats (
        .clk     (clk),
        .rst_n   (rst_n),
        .drop_i  (drop),
        .count_o (drop_count)
    );

    // Credits held, packets stored and credits in the return stage add up to DEPTH.
    assert_conserve_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(credits) + int'(occ) + int'(ret)) == DEPTH);

    // The sender raises no push without credit.
    assert_send_needs_credit_R2: assert property (@(posedge clk) disable iff (!rst_n)
        send |-> (credits != '0));
endmodule

// File: tb/credit_droptail_link_test.sv
module credit_droptail_link_test;
    localparam int DEPTH  = 4;
    localparam int DATA_W = 32;
    localparam int CNT_W  = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              src_valid = 1'b0;
    logic              src_ready;
    logic [DATA_W-1:0] src_data = '0;
    logic              dst_valid;
    logic              dst_ready = 1'b0;
    logic [DATA_W-1:0] dst_data;
    logic [CNT_W-1:0]  drop_count;

    int checks = 0;
    int fails  = 0;
    int exp_drops = 0;
    bit done = 1'b0;
    logic [DATA_W-1:0] exp_q[$];
    logic [DATA_W-1:0] held;

    always #5 clk = ~clk;

    credit_droptail_link #(.DEPTH(DEPTH), .DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_valid  (src_valid),
        .src_ready  (src_ready),
        .src_data   (src_data),
        .dst_valid  (dst_valid),
        .dst_ready  (dst_ready),
        .dst_data   (dst_data),
        .drop_count (drop_count)
    );

    task automatic chk(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Driver: set inputs after the falling edge, then predict keep or discard.
    task automatic drive(input logic v, input logic [DATA_W-1:0] d, input logic r);
        @(negedge clk);
        src_valid = v;
        src_data  = d;
        dst_ready = r;
        #2;
        if (rst_n && v && src_ready) begin
            if (exp_q.size() == DEPTH - 1) exp_drops++;   // R4 discard prediction
            else exp_q.push_back(d);
        end
    endtask

    // Monitor: compare each delivered packet with the scoreboard (R3, R4).
    always @(negedge clk) begin
        #3;
        if (rst_n && dst_valid && dst_ready) begin
            if (exp_q.size() == 0) begin
                chk("R3 unexpected delivery", dst_data, '1);
            end else begin
                chk("R3 order", dst_data, exp_q.pop_front());
            end
        end
    end

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    endtask

    initial begin
        #2_000_000;
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        drive(0, '0, 0);
        // R1 reset state
        chk("R1 src_ready", src_ready, 1);
        chk("R1 dst_valid", dst_valid, 0);
        chk("R1 drop_count", drop_count, 0);

        // R3 streaming with a ready consumer
        for (int i = 0; i < 10; i++) drive(1, 32'hA000 + i, 1);
        for (int i = 0; i < 4; i++) drive(0, '0, 1);
        chk("R3 all delivered", exp_q.size(), 0);
        chk("R3 empty", dst_valid, 0);

        // R9 and R2: DEPTH back-to-back accepts, then no credit
        for (int k = 0; k < DEPTH; k++) begin
            drive(1, 32'hB000 + k, 0);
            chk("R9 accept with credit", src_ready, 1);
        end
        drive(1, 32'hB0FF, 0);
        chk("R2 no credit", src_ready, 0);
        chk("R4 drop counted", drop_count, 1);

        // R7 stalled head held
        drive(0, '0, 0);
        held = dst_data;
        drive(0, '0, 0);
        chk("R7 valid held", dst_valid, 1);
        chk("R7 data held", dst_data, held);

        // R5 one delivery returns one spendable credit
        drive(0, '0, 1);
        drive(0, '0, 0);
        drive(0, '0, 0);
        drive(1, 32'hC000, 0);
        chk("R5 first send", src_ready, 1);
        drive(1, 32'hC001, 0);
        chk("R5 returned credit", src_ready, 1);
        drive(0, '0, 0);
        chk("R2 credit spent", src_ready, 0);

        // R6 delivery and discard in one cycle return two credits
        drive(1, 32'hD000, 1);
        chk("R6 send with credit", src_ready, 1);
        drive(0, '0, 0);
        chk("R6 return in flight", src_ready, 0);
        drive(1, 32'hD001, 0);
        chk("R6 first credit", src_ready, 1);
        drive(1, 32'hD002, 0);
        chk("R6 second credit", src_ready, 1);
        drive(0, '0, 0);
        chk("R4 drop total", drop_count, exp_drops);

        // Drain and confirm the kept packets came out in order
        for (int i = 0; i < 6; i++) drive(0, '0, 1);
        chk("R4 kept packets delivered", exp_q.size(), 0);

        // R8 saturation under sustained discards
        for (int i = 0; i < 700; i++) drive(1, 32'hE000 + i, 0);
        drive(0, '0, 0);
        chk("R8 enough drops", (exp_drops > 255) ? 1 : 0, 1);
        chk("R8 saturated", drop_count, 255);
        for (int i = 0; i < 6; i++) drive(0, '0, 1);
        chk("R8 drained", exp_q.size(), 0);

        finish_run();
    end
endmodule